// File: doc/BRIEF.md
# Indirect Post-Increment Move Unit

This unit is a multicycle execution slice for an 8-bit accumulator core. It carries out two move instructions that reach data memory through a pointer that is itself stored in data memory. The instruction's operand byte names a memory cell, and that cell holds a pointer. The load form copies the byte the pointer selects into the accumulator. The store form copies the accumulator into the byte the pointer selects. In both forms the pointer is then advanced by one and written back into its own cell, so repeated instructions walk through a buffer.

The core raises `start` for one cycle with the opcode and the operand. The unit then drives a synchronous single-port data memory, at most one access per cycle, and pads the idle cycles so that the `done` strobe always lands on the same cycle. The load form writes the accumulator and the zero flag as it finishes. The store form touches neither of them.

Top module: `ptr_move_unit`

## Requirements
- R1: With opcode 0x3E (load form), the accumulator receives the byte stored at the address held in memory[operand].
- R2: With opcode 0x3F (store form), the accumulator value is written to memory at the address held in memory[operand], and `acc_we` stays low.
- R3: `done` is high for exactly one cycle: the tenth cycle after the clock edge that accepts `start`. It is low in cycles one to nine.
- R4: The data access uses the pointer value read at the start of the instruction. The pointer cell is then rewritten with that old value plus one.
- R5: The pointer increment wraps modulo 256, so 0xFF is written back as 0x00.
- R6: The load form sets `zflag` to 1 when the loaded byte is 0x00 and to 0 otherwise. The new value is visible from the cycle after `done`. The store form leaves `zflag` and the accumulator unchanged.
- R7: In the store form, when the pointer cell and the data target are the same address, the cell ends up holding the incremented pointer, because the pointer write-back comes last.
- R8: A `start` pulse that arrives while an instruction is in progress is ignored. The running instruction completes unchanged, and no second instruction runs.
- R9: A `start` pulse with any opcode other than 0x3E or 0x3F is ignored. No memory access takes place and `done` does not rise.
- R10: After reset, `done`, `zflag`, `mem_en` and `acc_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin an instruction |
| opcode | input | 8 | Instruction opcode, sampled with `start` |
| operand | input | 8 | Address of the pointer cell, sampled with `start` |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable (read when low) |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after a read |
| acc_in | input | 8 | Current accumulator value |
| acc_we | output | 1 | Accumulator write strobe |
| acc_wdata | output | 8 | Value written to the accumulator |
| zflag | output | 1 | Zero flag |
| done | output | 1 | Completion strobe |

## Verification
The assertions check, on every cycle, that `done` is a single-cycle pulse and that `start` during a busy instruction never restarts the sequence. They also check that the pointer written back equals the fetched pointer plus one, that the store form never writes the accumulator or changes the zero flag, and that an unknown opcode produces no memory access. The bench's scenarios have to show the end-to-end data movement through a memory model. These cover the exact tenth-cycle timing, the zero-flag value, wrap of the pointer from 0xFF, the store where the pointer cell and the data target coincide, and consecutive loads that walk a buffer.

// File: rtl/ptrmv_pkg.sv
package ptrmv_pkg;

    localparam int BYTE_W = 8;

    localparam logic [7:0] OPC_LOAD  = 8'h3E;
    localparam logic [7:0] OPC_STORE = 8'h3F;

    // Phase numbers of the fixed schedule; phase 0 is idle.
    localparam int PH_PTR_RD  = 1;  // read pointer cell
    localparam int PH_PTR_CAP = 2;  // capture pointer
    localparam int PH_XFER    = 3;  // data read (load) or write (store)
    localparam int PH_DAT_CAP = 4;  // capture loaded byte
    localparam int PH_INC     = 5;  // advance pointer
    localparam int PH_PTR_WR  = 6;  // write pointer back
    localparam int PH_MIN_LAT = 7;  // shortest legal latency

    function automatic logic opc_valid(input logic [7:0] opc);
        return (opc == OPC_LOAD) || (opc == OPC_STORE);
    endfunction

endpackage

// File: rtl/ptrmv_sequencer.sv
module ptrmv_sequencer
    import ptrmv_pkg::*;
#(
    parameter int LAT = 10,
    localparam int PW = $clog2(LAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    opcode,
    output logic          accept,
    output logic [PW-1:0] phase,
    output logic          is_load,
    output logic          done
);

    localparam logic [PW-1:0] PH_LAST = PW'(LAT);

    typedef struct packed {
        logic [PW-1:0] phase;
        logic          load;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d  = seq_q;
        accept = start && (seq_q.phase == '0) && opc_valid(opcode);
        if (accept) begin
            seq_d.phase = PW'(1);
            seq_d.load  = (opcode == OPC_LOAD);
        end else if (seq_q.phase == PH_LAST) begin
            seq_d.phase = '0;
        end else if (seq_q.phase != '0) begin
            seq_d.phase = seq_q.phase + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase   = seq_q.phase;
    assign is_load = seq_q.load;
    assign done    = (seq_q.phase == PH_LAST);

    // R8: a start seen mid-instruction never restarts the schedule
    a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase != '0 && start) |=> (seq_q.phase != PW'(1)));

    // R3: done is a one-cycle pulse
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/ptrmv_datapath.sv
module ptrmv_datapath
    import ptrmv_pkg::*;
#(
    parameter int W   = BYTE_W,
    parameter int LAT = 10,
    localparam int PW = $clog2(LAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [W-1:0]  operand,
    input  logic [PW-1:0] phase,
    input  logic          is_load,
    output logic          mem_en,
    output logic          mem_we,
    output logic [W-1:0]  mem_addr,
    output logic [W-1:0]  mem_wdata,
    input  logic [W-1:0]  mem_rdata,
    input  logic [W-1:0]  acc_in,
    output logic          acc_we,
    output logic [W-1:0]  acc_wdata,
    output logic          zflag
);

    localparam logic [PW-1:0] PH_LAST = PW'(LAT);

    typedef struct packed {
        logic [W-1:0] opnd;
        logic [W-1:0] ptr;
        logic [W-1:0] data;
        logic         z;
    } dp_s;

    dp_s dp_d, dp_q;

    always_comb begin
        dp_d      = dp_q;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = dp_q.opnd;
        mem_wdata = dp_q.ptr;
        acc_we    = 1'b0;
        acc_wdata = dp_q.data;

        if (accept) begin
            dp_d.opnd = operand;
        end

        unique case (phase)
            PW'(PH_PTR_RD): begin
                mem_en   = 1'b1;
                mem_addr = dp_q.opnd;
            end
            PW'(PH_PTR_CAP): begin
                dp_d.ptr = mem_rdata;
            end
            PW'(PH_XFER): begin
                mem_en    = 1'b1;
                mem_we    = !is_load;
                mem_addr  = dp_q.ptr;
                mem_wdata = acc_in;
            end
            PW'(PH_DAT_CAP): begin
                if (is_load) begin
                    dp_d.data = mem_rdata;
                end
            end
            PW'(PH_INC): begin
                dp_d.ptr = dp_q.ptr + W'(1);
            end
            PW'(PH_PTR_WR): begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dp_q.opnd;
                mem_wdata = dp_q.ptr;
            end
            PH_LAST: begin
                if (is_load) begin
                    acc_we = 1'b1;
                    dp_d.z = (dp_q.data == '0);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign zflag = dp_q.z;

    // R4, R5: written-back pointer is the byte fetched four cycles earlier plus one
    a_r4_ptr_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PW'(PH_PTR_WR)) |-> (mem_we && mem_wdata == W'($past(mem_rdata, 4) + W'(1))));

    // R6: store form keeps the zero flag
    a_r6_store_keeps_z: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LAST && !is_load) |=> $stable(zflag));

    // R2: store form never writes the accumulator
    a_r2_store_no_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != '0 && !is_load) |-> !acc_we);

endmodule

// File: rtl/ptr_move_unit.sv
module ptr_move_unit
    import ptrmv_pkg::*;
#(
    parameter int LAT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [BYTE_W-1:0] operand,
    output logic              mem_en,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic [BYTE_W-1:0] acc_in,
    output logic              acc_we,
    output logic [BYTE_W-1:0] acc_wdata,
    output logic              zflag,
    output logic              done
);

    localparam int PW = $clog2(LAT + 1);

    logic          accept;
    logic [PW-1:0] phase;
    logic          is_load;

    ptrmv_sequencer #(.LAT(LAT)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .opcode  (opcode),
        .accept  (accept),
        .phase   (phase),
        .is_load (is_load),
        .done    (done)
    );

    ptrmv_datapath #(.W(BYTE_W), .LAT(LAT)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .operand   (operand),
        .phase     (phase),
        .is_load   (is_load),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .acc_in    (acc_in),
        .acc_we    (acc_we),
        .acc_wdata (acc_wdata),
        .zflag     (zflag)
    );

    initial begin
        a_lat_range: assert (LAT >= PH_MIN_LAT);
    end

    // R9: an unknown opcode at idle causes no memory access
    a_r9_bad_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == '0 && start && !opc_valid(opcode)) |=> !mem_en);

endmodule

// File: tb/sim_ptr_move_unit.sv
`timescale 1ns/1ps
module sim_ptr_move_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] opcode = 8'h00;
    logic [7:0] operand = 8'h00;
    logic       mem_en, mem_we, acc_we, zflag, done;
    logic [7:0] mem_addr, mem_wdata, acc_wdata;
    logic [7:0] mem_rdata = 8'h00;
    logic [7:0] acc = 8'h00;
    logic [7:0] mem [0:255];

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ptr_move_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .operand(operand),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .acc_in(acc), .acc_we(acc_we), .acc_wdata(acc_wdata),
        .zflag(zflag), .done(done)
    );

    // synchronous single-port memory and accumulator models
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
        if (acc_we) acc <= acc_wdata;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // issue one instruction and verify the done timing (R3)
    task automatic run(input logic [7:0] opc, input logic [7:0] opnd);
        int early = 0;
        @(negedge clk);
        start = 1'b1; opcode = opc; operand = opnd;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        if (done) early++;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); @(negedge clk);
            if (done) early++;
        end
        chk("R3 done low in cycles 1-9", early, 0);
        @(posedge clk); @(negedge clk);
        chk("R3 done high in cycle 10", done, 1);
        @(posedge clk); @(negedge clk);
        chk("R3 done one cycle only", done, 0);
    endtask

    task automatic t_reset();
        chk("R10 done at reset", done, 0);
        chk("R10 zflag at reset", zflag, 0);
        chk("R10 mem_en at reset", mem_en, 0);
        chk("R10 acc_we at reset", acc_we, 0);
    endtask

    task automatic t_load_basic();
        mem[8'h10] = 8'h40; mem[8'h40] = 8'hA5; acc = 8'h00;
        run(8'h3E, 8'h10);
        chk("R1 load value", acc, 8'hA5);
        chk("R4 pointer advanced", mem[8'h10], 8'h41);
        chk("R6 z clear on nonzero", zflag, 0);
    endtask

    task automatic t_load_walk();
        mem[8'h41] = 8'h3C;
        run(8'h3E, 8'h10);
        chk("R4 second load uses advanced pointer", acc, 8'h3C);
        chk("R4 pointer advanced twice", mem[8'h10], 8'h42);
    endtask

    task automatic t_load_zero();
        mem[8'h20] = 8'h50; mem[8'h50] = 8'h00; acc = 8'h33;
        run(8'h3E, 8'h20);
        chk("R1 load zero value", acc, 8'h00);
        chk("R6 z set on zero", zflag, 1);
        chk("R4 pointer advanced", mem[8'h20], 8'h51);
    endtask

    task automatic t_store_basic();
        acc = 8'h5C; mem[8'h30] = 8'h80; mem[8'h80] = 8'h00;
        run(8'h3F, 8'h30);
        chk("R2 store value", mem[8'h80], 8'h5C);
        chk("R4 store pointer advanced", mem[8'h30], 8'h81);
        chk("R6 store keeps z", zflag, 1);
        chk("R6 store keeps accumulator", acc, 8'h5C);
    endtask

    task automatic t_wrap();
        mem[8'h31] = 8'hFF; mem[8'hFF] = 8'h77;
        run(8'h3E, 8'h31);
        chk("R1 load via 0xFF", acc, 8'h77);
        chk("R5 pointer wraps", mem[8'h31], 8'h00);
        chk("R6 z clear", zflag, 0);
    endtask

    task automatic t_same_addr();
        acc = 8'hC3; mem[8'h44] = 8'h44;
        run(8'h3F, 8'h44);
        chk("R7 write-back wins", mem[8'h44], 8'h45);
    endtask

    task automatic t_busy();
        int dones = 0;
        mem[8'h60] = 8'h70; mem[8'h70] = 8'h12;
        mem[8'h61] = 8'h90; mem[8'h90] = 8'hEE;
        acc = 8'h00;
        @(negedge clk);
        start = 1'b1; opcode = 8'h3E; operand = 8'h60;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); @(negedge clk);
        end
        start = 1'b1; opcode = 8'h3F; operand = 8'h61;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (done) dones++;
            @(posedge clk); @(negedge clk);
        end
        chk("R8 one done only", dones, 1);
        chk("R8 load completes", acc, 8'h12);
        chk("R8 no store target write", mem[8'h90], 8'hEE);
        chk("R8 second pointer untouched", mem[8'h61], 8'h90);
    endtask

    task automatic t_bad_opcode();
        int acc_cnt = 0;
        int dones = 0;
        @(negedge clk);
        start = 1'b1; opcode = 8'h3D; operand = 8'h10;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 14; i++) begin
            if (mem_en) acc_cnt++;
            if (done) dones++;
            @(posedge clk); @(negedge clk);
        end
        chk("R9 no memory access", acc_cnt, 0);
        chk("R9 no done", dones, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_load_basic();
        t_load_walk();
        t_load_zero();
        t_store_basic();
        t_wrap();
        t_same_addr();
        t_busy();
        t_bad_opcode();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule